// File: doc/BRIEF.md
# Wiper Position Register Bank

This block keeps the live wiper setting for a group of digitally controlled potentiometers. Each potentiometer owns one volatile position register, and each register is turned into a one-hot tap-select word that closes exactly one switch along its resistor string. The analog string is outside the block; only the select lines leave it.

A command decoder in front of the block turns serial commands into single-cycle strobes. A position can be set directly with a host value. It can be copied from one of the potentiometer's stored settings, either for one potentiometer or for all of them together. It can also be nudged one step at a time by an open-ended run of step pulses, each carrying a direction. Just after reset the block reloads every position from that potentiometer's stored setting 0. The stored settings come in on a flat bus from the nonvolatile store. Write protection does not apply to this block, so every load source is always accepted.

Top module: `wiper_bank`

## Requirements
- R1: While `rst_n` is low, every position reads 0 and each tap-select slice has only bit 0 set.
- R2: In every cycle after reset, each potentiometer's 64-bit slice of `tap_sel_o` (pot p at bits p*64 upward) has exactly one bit set, at the index equal to its position. Position 0 selects the low end (bit 0) and 63 selects the high end (bit 63).
- R3: On the first rising clock edge after `rst_n` goes high, every position loads that potentiometer's stored setting 0. This recall wins over any strobe in the same cycle.
- R4: With `wr_i` high, the potentiometer chosen by `pot_sel_i` loads `wr_data_i` at the next edge. The other potentiometers keep their positions.
- R5: With `xfer_i` high and `xfer_all_i` low, the chosen potentiometer loads its stored setting numbered `reg_sel_i`. The stored setting r of pot p sits at `dr_vals_i` bits (p*4+r)*6 upward.
- R6: With `xfer_i` and `xfer_all_i` both high, every potentiometer loads its own stored setting `reg_sel_i`, whatever `pot_sel_i` holds.
- R7: With `step_i` high, the chosen position moves up by one when `step_up_i` is 1 and down by one when it is 0.
- R8: A step up at 63 leaves the position at 63, and a step down at 0 leaves it at 0. There is no wraparound.
- R9: When several strobes hit the same potentiometer in one cycle, transfer wins over write, and write wins over step.
- R10: In a cycle with no strobe, all positions hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Release triggers the recall |
| wr_i | input | 1 | Direct write strobe |
| xfer_i | input | 1 | Stored-setting transfer strobe |
| xfer_all_i | input | 1 | Makes a transfer apply to all potentiometers |
| step_i | input | 1 | Single step pulse |
| step_up_i | input | 1 | Step direction: 1 moves toward the high end |
| pot_sel_i | input | 2 | Target potentiometer |
| reg_sel_i | input | 2 | Stored-setting index for transfers |
| wr_data_i | input | 6 | Value for direct writes |
| dr_vals_i | input | 96 | All stored settings, 6 bits each, pot-major |
| tap_sel_o | output | 256 | One-hot tap selects, 64 per potentiometer |
| pos_o | output | 24 | Current positions, 6 bits per potentiometer |

## Verification
The bench builds the block with its default parameters: four potentiometers, four stored settings each, and 6-bit positions. With these values both saturation ends, 0 and 63, can be reached in a few steps. They also make the full 64-line decode visible on every slice. A run of eight up-steps pushes one position through its ceiling. Same-cycle strobe mixes, and a write strobe held during the recall cycle, exercise every rung of the priority order.

// File: rtl/wiper_bank_pkg.sv
package wiper_bank_pkg;
    typedef enum logic [2:0] {
        SRC_HOLD   = 3'd0,
        SRC_STEP   = 3'd1,
        SRC_WRITE  = 3'd2,
        SRC_XFER   = 3'd3,
        SRC_RECALL = 3'd4
    } load_src_e;
endpackage

// File: rtl/wiper_src_sel.sv
module wiper_src_sel
    import wiper_bank_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  logic             recall_i,
    input  logic             xfer_hit_i,
    input  logic             wr_hit_i,
    input  logic             step_hit_i,
    input  logic             step_up_i,
    input  logic [POS_W-1:0] cur_i,
    input  logic [POS_W-1:0] recall_val_i,
    input  logic [POS_W-1:0] xfer_val_i,
    input  logic [POS_W-1:0] wr_val_i,
    output logic [POS_W-1:0] nxt_o
);
    localparam logic [POS_W-1:0] TOP_POS = '1;
    localparam logic [POS_W-1:0] BOT_POS = '0;

    load_src_e        src;
    logic [POS_W-1:0] stepped;

    // fixed priority: recall, transfer, write, step
    always_comb begin
        if (recall_i)        src = SRC_RECALL;
        else if (xfer_hit_i) src = SRC_XFER;
        else if (wr_hit_i)   src = SRC_WRITE;
        else if (step_hit_i) src = SRC_STEP;
        else                 src = SRC_HOLD;
    end

    // saturating single step
    always_comb begin
        if (step_up_i) stepped = (cur_i == TOP_POS) ? cur_i : cur_i + POS_W'(1);
        else           stepped = (cur_i == BOT_POS) ? cur_i : cur_i - POS_W'(1);
    end

    always_comb begin
        case (src)
            SRC_RECALL: nxt_o = recall_val_i;
            SRC_XFER:   nxt_o = xfer_val_i;
            SRC_WRITE:  nxt_o = wr_val_i;
            SRC_STEP:   nxt_o = stepped;
            default:    nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
    parameter int POS_W = 6,
    parameter int TAPS  = 1 << POS_W
) (
    input  logic [POS_W-1:0] pos_i,
    output logic [TAPS-1:0]  tap_o
);
    always_comb begin
        tap_o        = '0;
        tap_o[pos_i] = 1'b1;
    end
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank #(
    parameter int NUM_POTS = 4,
    parameter int NUM_DR   = 4,
    parameter int POS_W    = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_i,
    input  logic                             xfer_i,
    input  logic                             xfer_all_i,
    input  logic                             step_i,
    input  logic                             step_up_i,
    input  logic [$clog2(NUM_POTS)-1:0]      pot_sel_i,
    input  logic [$clog2(NUM_DR)-1:0]        reg_sel_i,
    input  logic [POS_W-1:0]                 wr_data_i,
    input  logic [NUM_POTS*NUM_DR*POS_W-1:0] dr_vals_i,
    output logic [NUM_POTS*(1<<POS_W)-1:0]   tap_sel_o,
    output logic [NUM_POTS*POS_W-1:0]        pos_o
);
    localparam int TAPS  = 1 << POS_W;
    localparam int PSEL_W = $clog2(NUM_POTS);

    typedef struct packed {
        logic                             recall_pend;
        logic [NUM_POTS-1:0][POS_W-1:0]   pos;
    } bank_state_t;

    bank_state_t state_q, state_d;

    logic [POS_W-1:0] dr_mem [NUM_POTS][NUM_DR];
    logic [POS_W-1:0] nxt_pos [NUM_POTS];

    for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
        localparam logic [PSEL_W-1:0] PID = PSEL_W'(p);

        for (genvar r = 0; r < NUM_DR; r++) begin : g_dr
            assign dr_mem[p][r] = dr_vals_i[(p*NUM_DR + r)*POS_W +: POS_W];
        end

        logic hit_xfer, hit_wr, hit_step;
        assign hit_xfer = xfer_i && (xfer_all_i || pot_sel_i == PID);
        assign hit_wr   = wr_i   && (pot_sel_i == PID);
        assign hit_step = step_i && (pot_sel_i == PID);

        wiper_src_sel #(.POS_W(POS_W)) u_sel (
            .recall_i     (state_q.recall_pend),
            .xfer_hit_i   (hit_xfer),
            .wr_hit_i     (hit_wr),
            .step_hit_i   (hit_step),
            .step_up_i    (step_up_i),
            .cur_i        (state_q.pos[p]),
            .recall_val_i (dr_mem[p][0]),
            .xfer_val_i   (dr_mem[p][reg_sel_i]),
            .wr_val_i     (wr_data_i),
            .nxt_o        (nxt_pos[p])
        );

        wiper_tap_decode #(.POS_W(POS_W), .TAPS(TAPS)) u_dec (
            .pos_i (state_q.pos[p]),
            .tap_o (tap_sel_o[p*TAPS +: TAPS])
        );

        assign pos_o[p*POS_W +: POS_W] = state_q.pos[p];
    end

    always_comb begin
        state_d             = state_q;
        state_d.recall_pend = 1'b0;
        for (int p = 0; p < NUM_POTS; p++) begin
            state_d.pos[p] = nxt_pos[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.recall_pend <= 1'b1;
            state_q.pos         <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/wiper_bank_chk.sv
module wiper_bank_chk #(
    parameter int NUM_POTS = 4,
    parameter int NUM_DR   = 4,
    parameter int POS_W    = 6
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             wr_i,
    input logic                             xfer_i,
    input logic                             xfer_all_i,
    input logic                             step_i,
    input logic                             step_up_i,
    input logic [$clog2(NUM_POTS)-1:0]      pot_sel_i,
    input logic [$clog2(NUM_DR)-1:0]        reg_sel_i,
    input logic [POS_W-1:0]                 wr_data_i,
    input logic [NUM_POTS*NUM_DR*POS_W-1:0] dr_vals_i,
    input logic [NUM_POTS*(1<<POS_W)-1:0]   tap_sel_o,
    input logic [NUM_POTS*POS_W-1:0]        pos_o
);
    localparam int TAPS = 1 << POS_W;
    localparam int PSEL_W = $clog2(NUM_POTS);
    localparam logic [POS_W-1:0] TOP_POS = '1;

    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R10: no strobe means no movement
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && !xfer_i && !wr_i && !step_i |=> $stable(pos_o));

    for (genvar p = 0; p < NUM_POTS; p++) begin : g_chk
        localparam logic [PSEL_W-1:0] PID = PSEL_W'(p);
        logic [POS_W-1:0] cur;
        assign cur = pos_o[p*POS_W +: POS_W];

        a_r2_tap_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(tap_sel_o[p*TAPS +: TAPS]) == 1 && tap_sel_o[p*TAPS + int'(cur)]);

        a_r3_recall: assert property (@(posedge clk) disable iff (!rst_n)
            !live_q |=> cur == $past(dr_vals_i[p*NUM_DR*POS_W +: POS_W]));

        a_r4_write: assert property (@(posedge clk) disable iff (!rst_n)
            live_q && wr_i && !xfer_i && pot_sel_i == PID |=> cur == $past(wr_data_i));

        a_r8_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
            live_q && step_i && step_up_i && !xfer_i && !wr_i && pot_sel_i == PID
            && cur == TOP_POS |=> cur == TOP_POS);

        a_r8_floor: assert property (@(posedge clk) disable iff (!rst_n)
            live_q && step_i && !step_up_i && !xfer_i && !wr_i && pot_sel_i == PID
            && cur == '0 |=> cur == '0);
    end

    logic unused_ok;
    assign unused_ok = ^{xfer_all_i, reg_sel_i};
endmodule

bind wiper_bank wiper_bank_chk #(
    .NUM_POTS(NUM_POTS), .NUM_DR(NUM_DR), .POS_W(POS_W)
) u_chk (.*);

// File: tb/wiper_bank_test.sv
module wiper_bank_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_i = 0, xfer_i = 0, xfer_all_i = 0, step_i = 0, step_up_i = 0;
    logic [1:0]   pot_sel_i = 0, reg_sel_i = 0;
    logic [5:0]   wr_data_i = 0;
    logic [95:0]  dr_vals_i;
    logic [255:0] tap_sel_o;
    logic [23:0]  pos_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [23:0] pos;
        string       tag;
    } exp_item_t;

    exp_item_t  sb_q[$];
    logic [5:0] model [4];
    logic [5:0] dr [4][4];

    always #10 clk = ~clk;

    wiper_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .xfer_i(xfer_i),
        .xfer_all_i(xfer_all_i), .step_i(step_i), .step_up_i(step_up_i),
        .pot_sel_i(pot_sel_i), .reg_sel_i(reg_sel_i), .wr_data_i(wr_data_i),
        .dr_vals_i(dr_vals_i), .tap_sel_o(tap_sel_o), .pos_o(pos_o)
    );

    function automatic logic [23:0] pack_model();
        logic [23:0] v;
        for (int p = 0; p < 4; p++) v[p*6 +: 6] = model[p];
        return v;
    endfunction

    task automatic push(string tag);
        exp_item_t it;
        it.pos = pack_model();
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic drive(bit w, bit x, bit all, bit s, bit up,
                         logic [1:0] pot, logic [1:0] rs, logic [5:0] d, string tag);
        @(negedge clk);
        wr_i = w; xfer_i = x; xfer_all_i = all; step_i = s; step_up_i = up;
        pot_sel_i = pot; reg_sel_i = rs; wr_data_i = d;
        for (int p = 0; p < 4; p++) begin
            if (x && (all || pot == 2'(p)))  model[p] = dr[p][rs];
            else if (w && pot == 2'(p))      model[p] = d;
            else if (s && pot == 2'(p)) begin
                if (up) model[p] = (model[p] == 6'd63) ? model[p] : model[p] + 6'd1;
                else    model[p] = (model[p] == 6'd0)  ? model[p] : model[p] - 6'd1;
            end
        end
        push(tag);
    endtask

    // monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (pos_o !== it.pos) begin
                    errors++;
                    $display("FAIL %s: pos got %h expected %h", it.tag, pos_o, it.pos);
                end
                checks++;
                for (int p = 0; p < 4; p++) begin
                    if (tap_sel_o[p*64 +: 64] !== (64'd1 << it.pos[p*6 +: 6])) begin
                        errors++;
                        $display("FAIL R2 (%s) pot %0d: taps got %h expected %h", it.tag, p,
                                 tap_sel_o[p*64 +: 64], 64'd1 << it.pos[p*6 +: 6]);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++) begin
                dr[p][r] = 6'((p*16 + r*5 + 3) & 63);
                dr_vals_i[(p*4 + r)*6 +: 6] = dr[p][r];
            end
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (pos_o !== 24'd0 || tap_sel_o !== {4{64'd1}}) begin
            errors++;
            $display("FAIL R1: pos got %h taps %h expected 0 / bit0", pos_o, tap_sel_o);
        end
        // R3: release reset with a competing write strobe
        @(negedge clk);
        rst_n = 1'b1; wr_i = 1'b1; pot_sel_i = 2'd0; wr_data_i = 6'd9;
        for (int p = 0; p < 4; p++) model[p] = dr[p][0];
        push("R3 recall");
        drive(1, 0, 0, 0, 0, 2'd1, 2'd0, 6'd63, "R4 write pot1");
        drive(0, 0, 0, 1, 1, 2'd1, 2'd0, 6'd0,  "R8 ceiling");
        drive(0, 0, 0, 1, 0, 2'd1, 2'd0, 6'd0,  "R7 step down");
        drive(0, 0, 0, 1, 1, 2'd2, 2'd0, 6'd0,  "R7 step up");
        drive(1, 0, 0, 0, 0, 2'd0, 2'd0, 6'd0,  "R4 write zero");
        drive(0, 0, 0, 1, 0, 2'd0, 2'd0, 6'd0,  "R8 floor");
        drive(0, 1, 0, 0, 0, 2'd3, 2'd2, 6'd0,  "R5 single xfer");
        drive(0, 1, 1, 0, 0, 2'd2, 2'd1, 6'd0,  "R6 global xfer");
        drive(1, 1, 0, 0, 0, 2'd2, 2'd3, 6'd5,  "R9 xfer over write");
        drive(1, 0, 0, 1, 1, 2'd1, 2'd0, 6'd7,  "R9 write over step");
        drive(0, 0, 0, 0, 0, 2'd2, 2'd1, 6'd11, "R10 idle");
        drive(0, 0, 0, 0, 1, 2'd3, 2'd2, 6'd12, "R10 idle");
        for (int i = 0; i < 8; i++)
            drive(0, 0, 0, 1, 1, 2'd3, 2'd0, 6'd0, "R8 run to ceiling");
        drive(0, 1, 1, 1, 0, 2'd0, 2'd3, 6'd0,  "R6 global over step");
        drive(0, 0, 0, 0, 0, 2'd0, 2'd0, 6'd0,  "R10 idle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule